// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block sequences the low-power state of a small 8-bit processor core. When the core strobes that it is executing its sleep instruction, the controller clears the watchdog, updates two status flags and gates the core clock. It then waits on a free-running low-frequency clock for a wake cause. The causes are an external reset event, a watchdog expiry, or a peripheral interrupt whose own enable is set and whose source keeps running while the core clock is stopped.

On a wake the controller restarts the clock for a single restart cycle. In that cycle it clears the watchdog again and pulses a resume strobe. If the wake came from an interrupt and the global interrupt enable is set, it also pulses a vector strobe, so the core runs the prefetched next instruction and then branches to the interrupt vector. An external reset event never resumes: it raises the core reset instead. The power-down flag and the time-out flag together record why the core last reset or woke.

Top module: `slpwk_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `pwrdn_flag`=1, `timeout_flag`=1, `core_clk_en`=1, and `resume_pulse`, `vector_pulse`, `core_reset` and `wdt_clear` are 0.
- R2: A `sleep_strobe` in the run state with no enabled interrupt pending raises `wdt_clear` in that cycle. From the next cycle on, `core_clk_en`=0, `pwrdn_flag`=0 and `timeout_flag`=1.
- R3: In sleep, an interrupt source whose `irq_enable` bit is set and whose `ASYNC_MASK` bit is 1 wakes the core once its flag has passed the `SYNC_STAGES`-deep synchronizer. The wake is a single cycle with `core_clk_en`=1, `wdt_clear`=1 and `resume_pulse`=1, followed by the run state.
- R4: On an interrupt wake, `vector_pulse` equals `glb_int_en` in the restart cycle. The global enable has no effect on whether the wake happens.
- R5: A `wdt_expired` in sleep wakes the core the next cycle with `resume_pulse`=1, `vector_pulse`=0 (even with `glb_int_en`=1), `timeout_flag`=0 and `pwrdn_flag`=0.
- R6: An external reset event in sleep raises `core_reset` once it has been synchronized, with `resume_pulse`=0. The core clock is back on the next cycle, and both status flags keep their values.
- R7: A `wdt_expired` in the run state raises `core_reset` without `wdt_clear`. The next cycle shows `timeout_flag`=0 and `pwrdn_flag`=1.
- R8: A `sleep_strobe` while any flag-and-enable pair is already set (any source) skips the sleep state. The next cycle is the restart cycle, with `pwrdn_flag`=0 and `vector_pulse`=`glb_int_en`.
- R9: Simultaneous causes are ranked external reset, then watchdog, then interrupt. External plus watchdog gives a reset with no resume. Watchdog plus interrupt gives a watchdog wake with no vector.
- R10: An external reset event in the run state raises `core_reset` and leaves both status flags unchanged.
- R11: In sleep, a flag whose enable bit is clear, or whose `ASYNC_MASK` bit is 0, never wakes the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running low-frequency clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| sleep_strobe | input | 1 | Core is executing its sleep instruction |
| ext_reset_evt | input | 1 | Asynchronous external reset event |
| wdt_expired | input | 1 | Watchdog time-out, synchronous to `clk` |
| irq_flag | input | N_IRQ | Asynchronous interrupt flags, one per source |
| irq_enable | input | N_IRQ | Individual interrupt enables |
| glb_int_en | input | 1 | Global interrupt enable |
| core_clk_en | output | 1 | Core clock enable (0 while asleep) |
| wdt_clear | output | 1 | Clear the watchdog counter |
| resume_pulse | output | 1 | Restart at the prefetched next instruction |
| vector_pulse | output | 1 | After that instruction, branch to the interrupt vector |
| core_reset | output | 1 | Full core reset request |
| pwrdn_flag | output | 1 | Power-down status flag |
| timeout_flag | output | 1 | Time-out status flag |

## Verification
The bench builds the block with four interrupt sources, `ASYNC_MASK`=4'b1011 and a two-stage synchronizer. This gives both an asynchronous source and a core-clocked source in one build. The same core-clocked source therefore fails to wake a sleeping core (R11) and yet triggers the immediate wake path (R8). Because the watchdog input is synchronous and the other inputs pass through two flops, the bench can time a watchdog expiry so that it lands in the same cycle as a synchronized external or interrupt event. This is how it exercises the priority order.

// File: rtl/slpwk_pkg.sv
// Shared types for the sleep/wake controller.
package slpwk_pkg;
    // Power sequencing state.
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } pwr_state_e;

    // Winning wake or reset cause after arbitration.
    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_EXT  = 2'd1,
        WK_WDT  = 2'd2,
        WK_IRQ  = 2'd3
    } wake_cause_e;
endpackage

// File: rtl/slpwk_sync.sv
// Multi-stage synchronizer for a vector of asynchronous level inputs.
// Assumes each bit is independent; no bus coherency is provided.
module slpwk_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // One flop stage; stage 0 samples the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[s] <= '0;
                end else if (s == 0) begin
                    chain_q[s] <= async_in;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/slpwk_arb.sv
// Fixed-priority arbiter for wake causes: external > watchdog > interrupt.
// Assumes callers have already masked interrupt requests by state.
module slpwk_arb
    import slpwk_pkg::*;
(
    input  logic        ext_req,
    input  logic        wdt_req,
    input  logic        irq_req,
    output wake_cause_e cause
);
    // Pick the highest-ranked active request.
    always_comb begin
        if (ext_req)      cause = WK_EXT;
        else if (wdt_req) cause = WK_WDT;
        else if (irq_req) cause = WK_IRQ;
        else              cause = WK_NONE;
    end
endmodule

// File: rtl/slpwk_status.sv
// Power-down and time-out status flags.
// Assumes at most one event input is high per cycle.
module slpwk_status (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_sleep,
    input  logic evt_wdt_wake,
    input  logic evt_wdt_rst,
    output logic pd_q,
    output logic to_q
);
    // Power-down flag: set on power-up and watchdog reset, cleared on sleep entry.
    always_ff @(posedge clk) begin
        if (!rst_n)           pd_q <= 1'b1;
        else if (evt_sleep)   pd_q <= 1'b0;
        else if (evt_wdt_rst) pd_q <= 1'b1;
    end

    // Time-out flag: set on power-up and sleep entry, cleared by any watchdog expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                          to_q <= 1'b1;
        else if (evt_sleep)                  to_q <= 1'b1;
        else if (evt_wdt_wake || evt_wdt_rst) to_q <= 1'b0;
    end
endmodule

// File: rtl/slpwk_ctrl.sv
// Sleep/wake sequencer top: RUN -> SLEEP -> WAKE (one cycle) -> RUN.
// Runs on a free-running clock; asynchronous flags and the external
// reset event are synchronized here, the watchdog input is not.
module slpwk_ctrl
    import slpwk_pkg::*;
#(
    parameter int                 N_IRQ       = 4,
    parameter logic [N_IRQ-1:0]   ASYNC_MASK  = 4'b1011,
    parameter int                 SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_strobe,
    input  logic             ext_reset_evt,
    input  logic             wdt_expired,
    input  logic [N_IRQ-1:0] irq_flag,
    input  logic [N_IRQ-1:0] irq_enable,
    input  logic             glb_int_en,
    output logic             core_clk_en,
    output logic             wdt_clear,
    output logic             resume_pulse,
    output logic             vector_pulse,
    output logic             core_reset,
    output logic             pwrdn_flag,
    output logic             timeout_flag
);
    localparam int SYNC_W = N_IRQ + 1;

    pwr_state_e       state_q, state_d;
    wake_cause_e      cause;
    logic             wake_irq_q, wake_irq_d;
    logic [SYNC_W-1:0] sync_vec;
    logic [N_IRQ-1:0] flag_s;
    logic             ext_s;
    logic             pend_any, pend_async;
    logic             evt_sleep, evt_wdt_wake, evt_wdt_rst;

    slpwk_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ext_reset_evt, irq_flag}),
        .sync_out (sync_vec)
    );

    assign flag_s     = sync_vec[N_IRQ-1:0];
    assign ext_s      = sync_vec[N_IRQ];
    assign pend_any   = |(flag_s & irq_enable);
    assign pend_async = |(flag_s & irq_enable & ASYNC_MASK);

    slpwk_arb u_arb (
        .ext_req (ext_s),
        .wdt_req (wdt_expired),
        .irq_req (pend_async && (state_q == ST_SLEEP)),
        .cause   (cause)
    );

    // Next-state and status-event decode.
    always_comb begin
        state_d      = state_q;
        wake_irq_d   = wake_irq_q;
        evt_sleep    = 1'b0;
        evt_wdt_wake = 1'b0;
        evt_wdt_rst  = 1'b0;
        case (state_q)
            ST_RUN: begin
                if (cause == WK_WDT) begin
                    evt_wdt_rst = 1'b1;
                end else if (cause == WK_NONE && sleep_strobe) begin
                    evt_sleep = 1'b1;
                    if (pend_any) begin
                        state_d    = ST_WAKE;
                        wake_irq_d = 1'b1;
                    end else begin
                        state_d = ST_SLEEP;
                    end
                end
            end
            ST_SLEEP: begin
                case (cause)
                    WK_EXT: state_d = ST_RUN;
                    WK_WDT: begin
                        evt_wdt_wake = 1'b1;
                        state_d      = ST_WAKE;
                        wake_irq_d   = 1'b0;
                    end
                    WK_IRQ: begin
                        state_d    = ST_WAKE;
                        wake_irq_d = 1'b1;
                    end
                    default: state_d = ST_SLEEP;
                endcase
            end
            ST_WAKE: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // State and wake-source registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_RUN;
            wake_irq_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            wake_irq_q <= wake_irq_d;
        end
    end

    slpwk_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_sleep    (evt_sleep),
        .evt_wdt_wake (evt_wdt_wake),
        .evt_wdt_rst  (evt_wdt_rst),
        .pd_q         (pwrdn_flag),
        .to_q         (timeout_flag)
    );

    // Output decode from state and arbitration result.
    always_comb begin
        core_clk_en  = (state_q != ST_SLEEP);
        core_reset   = (cause == WK_EXT) || (state_q == ST_RUN && cause == WK_WDT);
        resume_pulse = (state_q == ST_WAKE) && (cause != WK_EXT);
        vector_pulse = resume_pulse && wake_irq_q && glb_int_en;
        wdt_clear    = evt_sleep || (state_q == ST_WAKE);
    end
endmodule

// File: rtl/slpwk_chk.sv
// Port-level property checker for slpwk_ctrl, attached by bind.
module slpwk_chk (
    input logic clk,
    input logic rst_n,
    input logic glb_int_en,
    input logic wdt_expired,
    input logic core_clk_en,
    input logic wdt_clear,
    input logic resume_pulse,
    input logic vector_pulse,
    input logic core_reset,
    input logic pwrdn_flag
);
    assert_sleep_clears_pd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_clear && core_clk_en && !resume_pulse && !core_reset) |=> !pwrdn_flag);

    assert_asleep_pd_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !core_clk_en |-> !pwrdn_flag);

    assert_restart_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> (core_clk_en && wdt_clear));

    assert_restart_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |=> !resume_pulse);

    assert_vector_needs_gie_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vector_pulse |-> (resume_pulse && glb_int_en));

    assert_reset_no_resume_R6: assert property (@(posedge clk) disable iff (!rst_n)
        core_reset |-> (!resume_pulse && !vector_pulse));

    assert_ext_keeps_pd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (core_reset && !wdt_expired) |=> $stable(pwrdn_flag));
endmodule

bind slpwk_ctrl slpwk_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .glb_int_en   (glb_int_en),
    .wdt_expired  (wdt_expired),
    .core_clk_en  (core_clk_en),
    .wdt_clear    (wdt_clear),
    .resume_pulse (resume_pulse),
    .vector_pulse (vector_pulse),
    .core_reset   (core_reset),
    .pwrdn_flag   (pwrdn_flag)
);

// File: tb/sim_slpwk_ctrl.sv
module sim_slpwk_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam int  N_IRQ      = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_strobe = 1'b0, ext_reset_evt = 1'b0, wdt_expired = 1'b0, glb_int_en = 1'b0;
    logic [N_IRQ-1:0] irq_flag = '0, irq_enable = '0;
    logic core_clk_en, wdt_clear, resume_pulse, vector_pulse, core_reset, pwrdn_flag, timeout_flag;
    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slpwk_ctrl #(.N_IRQ(N_IRQ), .ASYNC_MASK(4'b1011), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_strobe(sleep_strobe), .ext_reset_evt(ext_reset_evt),
        .wdt_expired(wdt_expired), .irq_flag(irq_flag), .irq_enable(irq_enable),
        .glb_int_en(glb_int_en), .core_clk_en(core_clk_en), .wdt_clear(wdt_clear),
        .resume_pulse(resume_pulse), .vector_pulse(vector_pulse), .core_reset(core_reset),
        .pwrdn_flag(pwrdn_flag), .timeout_flag(timeout_flag)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic clear_irqs();
        irq_flag = '0;
        irq_enable = '0;
        step(3);
    endtask

    task automatic go_sleep(input string tag);
        sleep_strobe = 1'b1;
        #1;
        check({tag, " wdt_clear on entry"}, wdt_clear, 1'b1);
        step();
        sleep_strobe = 1'b0;
        #1;
        check({tag, " clock gated"}, core_clk_en, 1'b0);
        check({tag, " pd cleared"}, pwrdn_flag, 1'b0);
        check({tag, " to set"}, timeout_flag, 1'b1);
    endtask

    task automatic t_reset();
        #1;
        check("R1 pd in reset", pwrdn_flag, 1'b1);
        step(2);
        rst_n = 1'b1;
        step();
        check("R1 pd", pwrdn_flag, 1'b1);
        check("R1 to", timeout_flag, 1'b1);
        check("R1 clk_en", core_clk_en, 1'b1);
        check("R1 resume", resume_pulse, 1'b0);
        check("R1 reset out", core_reset, 1'b0);
        check("R1 wdt_clear", wdt_clear, 1'b0);
    endtask

    task automatic t_irq_wake(input logic g);
        go_sleep("R2");
        glb_int_en = g;
        irq_flag[0] = 1'b1;
        irq_enable[0] = 1'b1;
        step(2);
        check("R3 still asleep while syncing", core_clk_en, 1'b0);
        step();
        check("R3 restart clk_en", core_clk_en, 1'b1);
        check("R3 restart resume", resume_pulse, 1'b1);
        check("R3 restart wdt_clear", wdt_clear, 1'b1);
        check("R4 vector follows gie", vector_pulse, g);
        step();
        check("R3 back to run, no resume", resume_pulse, 1'b0);
        clear_irqs();
    endtask

    task automatic t_wdt_wake();
        go_sleep("R5 entry");
        glb_int_en = 1'b1;
        wdt_expired = 1'b1;
        #1;
        check("R5 no reset on sleep wdt", core_reset, 1'b0);
        step();
        wdt_expired = 1'b0;
        #1;
        check("R5 resume", resume_pulse, 1'b1);
        check("R5 no vector", vector_pulse, 1'b0);
        check("R5 to cleared", timeout_flag, 1'b0);
        check("R5 pd stays 0", pwrdn_flag, 1'b0);
        step();
    endtask

    task automatic t_ext_sleep();
        go_sleep("R6 entry");
        ext_reset_evt = 1'b1;
        step();
        ext_reset_evt = 1'b0;
        step();
        check("R6 reset raised", core_reset, 1'b1);
        check("R6 no resume", resume_pulse, 1'b0);
        step();
        check("R6 clock back", core_clk_en, 1'b1);
        check("R6 pd kept", pwrdn_flag, 1'b0);
        check("R6 to kept", timeout_flag, 1'b1);
        check("R6 reset single", core_reset, 1'b0);
    endtask

    task automatic t_priority();
        go_sleep("R9 entry a");
        ext_reset_evt = 1'b1;
        irq_flag[0] = 1'b1;
        irq_enable[0] = 1'b1;
        step();
        ext_reset_evt = 1'b0;
        step();
        wdt_expired = 1'b1;
        #1;
        check("R9 ext beats wdt: reset", core_reset, 1'b1);
        check("R9 ext beats wdt: no resume", resume_pulse, 1'b0);
        step();
        wdt_expired = 1'b0;
        #1;
        check("R9 ext beats wdt: to kept", timeout_flag, 1'b1);
        check("R9 ext beats wdt: not in restart", resume_pulse, 1'b0);
        clear_irqs();
        go_sleep("R9 entry b");
        glb_int_en = 1'b1;
        irq_flag[0] = 1'b1;
        irq_enable[0] = 1'b1;
        step(2);
        wdt_expired = 1'b1;
        step();
        wdt_expired = 1'b0;
        #1;
        check("R9 wdt beats irq: resume", resume_pulse, 1'b1);
        check("R9 wdt beats irq: no vector", vector_pulse, 1'b0);
        check("R9 wdt beats irq: to cleared", timeout_flag, 1'b0);
        clear_irqs();
    endtask

    task automatic t_masked();
        go_sleep("R11 entry");
        irq_flag[2] = 1'b1;
        irq_enable[2] = 1'b1;
        irq_flag[1] = 1'b1;
        irq_enable[1] = 1'b0;
        step(4);
        check("R11 non-async/disabled no wake", core_clk_en, 1'b0);
        check("R11 no resume", resume_pulse, 1'b0);
        wdt_expired = 1'b1;
        step();
        wdt_expired = 1'b0;
        step();
        clear_irqs();
    endtask

    task automatic t_immediate();
        glb_int_en = 1'b1;
        irq_flag[2] = 1'b1;
        irq_enable[2] = 1'b1;
        step(3);
        sleep_strobe = 1'b1;
        #1;
        check("R8 wdt_clear on sleep", wdt_clear, 1'b1);
        step();
        sleep_strobe = 1'b0;
        #1;
        check("R8 direct restart", resume_pulse, 1'b1);
        check("R8 clock never gated", core_clk_en, 1'b1);
        check("R8 pd cleared", pwrdn_flag, 1'b0);
        check("R8 vector", vector_pulse, 1'b1);
        step();
        check("R8 run after restart", core_clk_en, 1'b1);
        clear_irqs();
    endtask

    task automatic t_wdt_run();
        wdt_expired = 1'b1;
        #1;
        check("R7 reset raised", core_reset, 1'b1);
        check("R7 no wdt_clear", wdt_clear, 1'b0);
        step();
        wdt_expired = 1'b0;
        #1;
        check("R7 pd set", pwrdn_flag, 1'b1);
        check("R7 to cleared", timeout_flag, 1'b0);
    endtask

    task automatic t_ext_run();
        ext_reset_evt = 1'b1;
        step();
        ext_reset_evt = 1'b0;
        step();
        check("R10 reset raised", core_reset, 1'b1);
        step();
        check("R10 pd kept", pwrdn_flag, 1'b1);
        check("R10 to kept", timeout_flag, 1'b0);
        check("R10 reset single", core_reset, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_irq_wake(1'b0);
        t_irq_wake(1'b1);
        t_wdt_wake();
        t_ext_sleep();
        t_priority();
        t_masked();
        t_immediate();
        t_wdt_run();
        t_ext_run();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule